// File: doc/BRIEF.md
# Horizontal Crop Stage

This stage sits in one channel of a pixel pipeline, between the read DMA and the compositor. It accepts a valid/ready stream of pixels, one per beat. A start-of-frame flag marks the first pixel of each frame. The stage discards a configurable run of pixels at the left edge of every line and another at the right edge, and forwards the remaining window as a narrower valid/ready stream. That output stream carries start-of-frame, end-of-line and end-of-frame markers. Rows are never removed: row selection is done upstream by where the DMA starts reading, so the output frame has as many lines as the input frame.

Software programs a bypass bit, a packed size word and a packed crop word. The live values are copied into shadow registers only on an accepted start-of-frame beat, and only while the channel is enabled, so a frame is always processed with one consistent setting. Line width and height use a minus-one encoding. The right crop field uses the same encoding: a field value of R discards R+1 pixels. For a window of width w at offset x inside a line of width W, software writes left = x and right field = W - (x + w) - 1. When w equals W it sets bypass instead and writes zero to both crop amounts.

Top module: `hcrop_stage`

## Requirements
- R1: While reset is held and on the first cycle after it, `outValid` is 0 and `inReady` is 1.
- R2: With the shadow bypass bit set, every input pixel is forwarded unchanged and in order. `outEol` is set on column W-1 of each line.
- R3: With bypass clear, the first L pixels of every line are discarded. L is the left amount.
- R4: With bypass clear and right field R, the last R+1 pixels of every line are discarded. Columns L through W-2-R are forwarded.
- R5: `cfgSize[31:16]` holds W-1 and `cfgSize[15:0]` holds H-1. `cfgCrop[31:16]` holds L and `cfgCrop[15:0]` holds R.
- R6: While `outValid` is 1 and `outReady` is 0, the output beat stays unchanged. Input is stalled (`inReady` is 0), no pixel is lost and order is kept.
- R7: Live configuration is copied into the shadow only on an accepted beat with `inSof` = 1 and `chanEnable` = 1. That beat already uses the new values. Changes made mid-frame have no effect until the next such beat.
- R8: An accepted start-of-frame beat with `chanEnable` = 0 leaves the shadow unchanged, so the previous settings stay in force.
- R9: `outSof` is set on the first forwarded pixel of a frame, even when the input start-of-frame pixel itself is discarded.
- R10: `outEol` is set on the last forwarded pixel of each line. `outEof` is set on the last forwarded pixel of row H-1.
- R11: Height passes through unchanged: an input frame of H lines yields H output lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanEnable | input | 1 | Channel enable; gates shadow reload |
| cfgBypass | input | 1 | Live bypass bit |
| cfgSize | input | 32 | Live {W-1, H-1} |
| cfgCrop | input | 32 | Live {left, right field} |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Input pixel accepted when high with inValid |
| inData | input | PIX_W | Input pixel |
| inSof | input | 1 | Input start of frame |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Downstream ready |
| outData | output | PIX_W | Output pixel |
| outSof | output | 1 | First forwarded pixel of frame |
| outEol | output | 1 | Last forwarded pixel of line |
| outEof | output | 1 | Last forwarded pixel of frame |

## Verification
Some properties are checked on every cycle by the assertions. They confirm that a stalled output beat holds its data and markers, that an idle output register accepts input, and that end-of-frame never appears without end-of-line. They also confirm that the column counter stays inside the shadow line width and that the shadow cannot change without a permitted reload. Other behaviour can only be shown by the bench scenarios, which compare every output beat against a behavioural model. These cover which columns survive for a given left amount and right field, where the markers fall, that a mid-frame or disabled-channel reconfiguration is deferred, and that the line count is preserved.

// File: rtl/hcrop_pkg.sv
package hcrop_pkg;
  localparam int HC_DIM_W = 16;

  typedef struct packed {
    logic                bypass;
    logic [HC_DIM_W-1:0] wM1;
    logic [HC_DIM_W-1:0] hM1;
    logic [HC_DIM_W-1:0] left;
    logic [HC_DIM_W-1:0] rightF;
  } cropCfg_t;

  typedef struct packed {
    logic keep;
    logic sof;
    logic eol;
    logic eof;
  } cropStrobe_t;
endpackage

// File: rtl/hcrop_ctrl.sv
module hcrop_ctrl
  import hcrop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        beat,
  input  logic        inSof,
  input  logic        chanEnable,
  input  cropCfg_t    liveCfg,
  output cropStrobe_t strb
);
  localparam int EXT_W = HC_DIM_W + 2;

  cropCfg_t            shadowCfg;
  cropCfg_t            effCfg;
  logic [HC_DIM_W-1:0] col, row, colEff, rowEff;
  logic                sofPend;
  logic                loadNow, lastCol, inWin, eolHit, keep;
  logic [EXT_W-1:0]    tail, lineEnd;

  assign loadNow = beat && inSof && chanEnable;
  assign effCfg  = loadNow ? liveCfg : shadowCfg;
  assign colEff  = inSof ? '0 : col;
  assign rowEff  = inSof ? '0 : row;
  assign lastCol = (colEff == effCfg.wM1);
  assign tail    = {2'b00, colEff} + {2'b00, effCfg.rightF} + EXT_W'(1);
  assign lineEnd = {2'b00, effCfg.wM1};
  assign inWin   = (colEff >= effCfg.left) && (tail <= lineEnd);
  assign eolHit  = effCfg.bypass ? lastCol : (tail == lineEnd);
  assign keep    = beat && (effCfg.bypass || inWin);

  always_comb begin
    strb.keep = keep;
    strb.sof  = keep && (inSof || sofPend);
    strb.eol  = keep && eolHit;
    strb.eof  = keep && eolHit && (rowEff == effCfg.hM1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCfg <= '{bypass: 1'b1, default: '0};
      col       <= '0;
      row       <= '0;
      sofPend   <= 1'b0;
    end else begin
      if (loadNow) shadowCfg <= liveCfg;
      if (beat) begin
        col     <= lastCol ? '0 : colEff + HC_DIM_W'(1);
        row     <= lastCol ? rowEff + HC_DIM_W'(1) : rowEff;
        sofPend <= keep ? 1'b0 : (inSof ? 1'b1 : sofPend);
      end
    end
  end

  // R2: column position never leaves the line currently in force
  p_col_in_line_r2: assert property (@(posedge clk) disable iff (!rstN)
    beat |=> (col <= shadowCfg.wM1));

  // R8: shadow settings only move on a permitted reload beat
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !loadNow |=> $stable(shadowCfg));
endmodule

// File: rtl/hcrop_dp.sv
module hcrop_dp
  import hcrop_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] inData,
  input  cropStrobe_t      strb,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output logic [PIX_W-1:0] outData,
  output logic             outSof,
  output logic             outEol,
  output logic             outEof
);
  assign inReady = !outValid || outReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outSof   <= 1'b0;
      outEol   <= 1'b0;
      outEof   <= 1'b0;
    end else if (strb.keep) begin
      outValid <= 1'b1;
      outData  <= inData;
      outSof   <= strb.sof;
      outEol   <= strb.eol;
      outEof   <= strb.eof;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  // R6: a stalled beat is held intact
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)
                                 && $stable(outSof) && $stable(outEol)));
endmodule

// File: rtl/hcrop_stage.sv
module hcrop_stage
  import hcrop_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  chanEnable,
  input  logic                  cfgBypass,
  input  logic [2*HC_DIM_W-1:0] cfgSize,
  input  logic [2*HC_DIM_W-1:0] cfgCrop,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [PIX_W-1:0]      inData,
  input  logic                  inSof,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [PIX_W-1:0]      outData,
  output logic                  outSof,
  output logic                  outEol,
  output logic                  outEof
);
  cropCfg_t    liveCfg;
  cropStrobe_t strb;
  logic        beat;

  assign liveCfg.bypass = cfgBypass;
  assign liveCfg.wM1    = cfgSize[2*HC_DIM_W-1:HC_DIM_W];
  assign liveCfg.hM1    = cfgSize[HC_DIM_W-1:0];
  assign liveCfg.left   = cfgCrop[2*HC_DIM_W-1:HC_DIM_W];
  assign liveCfg.rightF = cfgCrop[HC_DIM_W-1:0];
  assign beat           = inValid && inReady;

  hcrop_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .beat(beat), .inSof(inSof),
    .chanEnable(chanEnable), .liveCfg(liveCfg), .strb(strb)
  );

  hcrop_dp #(.PIX_W(PIX_W)) u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .strb(strb),
    .outReady(outReady), .inReady(inReady), .outValid(outValid),
    .outData(outData), .outSof(outSof), .outEol(outEol), .outEof(outEof)
  );

  // R10: frame end only ever coincides with a line end
  p_eof_is_eol_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outEof) |-> outEol);

  // R6: an empty output register never blocks the input
  p_ready_when_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);
endmodule

// File: tb/hcrop_stage_bench.sv
module hcrop_stage_bench;
  localparam int PER   = 10;
  localparam int PIX_W = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chanEnable = 1'b1, cfgBypass = 1'b1;
  logic [31:0] cfgSize = '0, cfgCrop = '0;
  logic inValid = 1'b0, inSof = 1'b0, outReady = 1'b1;
  logic [PIX_W-1:0] inData = '0;
  logic inReady, outValid, outSof, outEol, outEof;
  logic [PIX_W-1:0] outData;

  always #(PER/2) clk = ~clk;

  hcrop_stage #(.PIX_W(PIX_W)) u_hcrop_stage (
    .clk(clk), .rstN(rstN), .chanEnable(chanEnable), .cfgBypass(cfgBypass),
    .cfgSize(cfgSize), .cfgCrop(cfgCrop), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inSof(inSof), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outSof(outSof), .outEol(outEol), .outEof(outEof)
  );

  typedef struct { logic [PIX_W-1:0] d; bit s; bit e; bit f; } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0, eolSeen = 0, frameNo = 0;
  bit stallMode = 0, gapMode = 0, finished = 0;
  string tag = "R1";

  // reference state
  bit mByp = 1; int mWm1 = 0, mHm1 = 0, mL = 0, mR = 0;
  int mCol = 0, mRow = 0; bit mSofPend = 0;

  task automatic check(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic modelBeat();
    int c, r; bit k, e;
    if (inSof && chanEnable) begin
      mByp = cfgBypass; mWm1 = int'(cfgSize[31:16]); mHm1 = int'(cfgSize[15:0]);
      mL = int'(cfgCrop[31:16]); mR = int'(cfgCrop[15:0]);
    end
    c = inSof ? 0 : mCol;
    r = inSof ? 0 : mRow;
    if (mByp) begin
      k = 1; e = (c == mWm1);
    end else begin
      k = (c >= mL) && (c + mR + 1 <= mWm1);
      e = (c + mR + 1 == mWm1);
    end
    if (k) begin
      exp_t x;
      x.d = inData; x.s = inSof || mSofPend; x.e = e; x.f = e && (r == mHm1);
      q.push_back(x);
    end
    mSofPend = k ? 0 : (inSof ? 1 : mSofPend);
    if (c == mWm1) begin mCol = 0; mRow = r + 1; end
    else begin mCol = c + 1; mRow = r; end
  endtask

  task automatic sampleAll();
    bit inF, outF;
    inF  = inValid && inReady;
    outF = outValid && outReady;
    if (outValid && q.size() == 0)
      check(0, "unexpected output beat", outData, 0);
    if (outF && q.size() > 0) begin
      exp_t x = q.pop_front();
      check(outData == x.d, "data", outData, x.d);
      check(outSof == x.s && outEol == x.e && outEof == x.f, "markers",
            {outSof, outEol, outEof}, {x.s, x.e, x.f});
      if (outEol) eolSeen++;
    end
    if (inF) modelBeat();
  endtask

  // called right after a falling edge; returns at the next falling edge
  task automatic stepCycle(output bit acc);
    outReady = stallMode ? ($urandom % 3 != 0) : 1'b1;
    #(PER/2 - 1);
    acc = inValid && inReady;
    sampleAll();
    @(negedge clk);
  endtask

  task automatic sendPix(int row, int col, bit sof);
    bit acc;
    if (gapMode && ($urandom % 4 == 0)) stepCycle(acc);
    inValid = 1; inSof = sof;
    inData = {8'(frameNo), 8'(row), 8'(col)};
    do stepCycle(acc); while (!acc);
    inValid = 0; inSof = 0;
  endtask

  task automatic sendLine(int w, int row, bit first);
    for (int c = 0; c < w; c++) sendPix(row, c, first && c == 0);
  endtask

  task automatic drain();
    bit acc;
    inValid = 0;
    stallMode = 0;
    for (int i = 0; i < 200 && (q.size() > 0 || outValid); i++) stepCycle(acc);
    check(q.size() == 0 && !outValid, "drain leftover", q.size(), 0);
  endtask

  task automatic setCfg(bit byp, int w, int h, int l, int r);
    cfgBypass = byp;
    cfgSize = {16'(w - 1), 16'(h - 1)};
    cfgCrop = {16'(l), 16'(r)};
  endtask

  task automatic runFrame(int w, int h);
    eolSeen = 0;
    for (int r = 0; r < h; r++) sendLine(w, r, r == 0);
    drain();
    frameNo++;
  endtask

  initial begin
    #(PER * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    check(outValid == 0, "outValid in reset", outValid, 0);
    check(inReady == 1, "inReady in reset", inReady, 1);
    rstN = 1;
    @(negedge clk);
    check(outValid == 0 && inReady == 1, "idle after reset", {outValid, inReady}, 2'b01);

    tag = "R2 R5"; setCfg(1, 6, 2, 0, 0); runFrame(6, 2);
    check(eolSeen == 2, "bypass line count", eolSeen, 2);

    tag = "R3 R4 R10 R11"; setCfg(0, 10, 3, 2, 1); runFrame(10, 3);
    check(eolSeen == 3, "rows preserved", eolSeen, 3);

    tag = "R4"; setCfg(0, 5, 2, 0, 0); runFrame(5, 2);
    check(eolSeen == 2, "single right drop lines", eolSeen, 2);

    tag = "R6"; setCfg(0, 9, 3, 1, 2);
    stallMode = 1; gapMode = 1;
    eolSeen = 0;
    for (int r = 0; r < 3; r++) begin stallMode = 1; sendLine(9, r, r == 0); end
    drain(); frameNo++;
    check(eolSeen == 3, "rows under backpressure", eolSeen, 3);
    gapMode = 0;

    tag = "R7"; setCfg(0, 8, 3, 1, 0);
    sendLine(8, 0, 1);
    setCfg(0, 8, 3, 3, 2);
    sendLine(8, 1, 0); sendLine(8, 2, 0);
    drain(); frameNo++;
    runFrame(8, 3);

    tag = "R8"; chanEnable = 0; setCfg(1, 8, 2, 0, 0);
    runFrame(8, 2);
    check(eolSeen == 2, "disabled reload lines", eolSeen, 2);
    chanEnable = 1;
    tag = "R2 R8"; runFrame(8, 2);

    tag = "R9 R10"; setCfg(0, 8, 2, 5, 0); runFrame(8, 2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule